// File: doc/BRIEF.md
# Accelerator Parameter Shell

This block is a memory-mapped wrapper that lets a processor hand work to a compute core over an APB slave port. Software first writes the scalar and aggregate inputs. It then sets a start bit in a control word and polls that word until the core reports completion. Last, it reads back the scalar results and the updated aggregate data. All parameters of one core live in a single 4 KB window, and the bus and the core share one clock.

Scalar inputs are held in registers that feed the core's input pins directly. Scalar outputs are caught from the core's result pins when it signals completion. Aggregate data (array or structure elements) lives in a small local RAM that the core reaches through its own word port. Each bus offset is translated into an element index, and from that into a packed local word and byte lane. On the bus each element has a 32-bit slot. Inside the RAM elements are packed tightly, so the unused slot bytes are discarded on writes and returned as zero on reads. Every scalar and the aggregate region carry an elaboration-time byte-order flag, so that the core always works on little-endian values.

Top module: `acc_param_shell`

## Requirements
- R1: After reset the control word (offset 0x000) and every scalar input register read as zero, and `core_start` is low.
- R2: Every access completes in its access phase (`pready` high). An access to a word outside the map, or to an address with nonzero low two bits, raises `pslverr` in that phase, reads zero and changes nothing.
- R3: Scalar input k sits at offset 0x004+4k. A read returns the value written. When that input's byte-order flag is set, the core sees the written word with its four bytes reversed; otherwise it sees the word unchanged.
- R4: Scalar output j sits at offset 0x004+4*N_IN+4j. It captures the core's result on the cycle `core_done` is high while busy. A read returns that result, byte-reversed when the output's flag is set. Bus writes to it are ignored.
- R5: Writing a word with bit 0 set to the control word while idle raises `core_start` for exactly one cycle, starting the cycle after the write. From that same cycle the control word reads busy (bit 1) = 1 and done (bit 2) = 0. Bit 0 always reads 0.
- R6: When `core_done` is high while busy, the next cycle reads busy = 0 and done = 1. Done then stays set until the next accepted start.
- R7: A start written while busy is ignored and produces no further `core_start` pulse.
- R8: Aggregate element i has bus offset AGG_BASE+4i and occupies the low ELEM_BYTES bytes of that word. It is stored at local word i/(4/ELEM_BYTES), at lane i mod (4/ELEM_BYTES), with the lowest lane at the least significant bits. Bytes above the element width are dropped on write and read as zero.
- R9: When the aggregate byte-order flag is set, the bytes of each element are reversed on the way into the RAM and again on the way out.
- R10: Bus writes to the aggregate region while busy are ignored.
- R11: An offset past the last aggregate element (AGG_BASE+4*N_ELEM and above) is outside the map, per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Shared bus and core clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Tied high, no wait states |
| pslverr | output | 1 | Unmapped or misaligned access |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_done | input | 1 | Core completion pulse |
| scalar_in | output | 32*N_IN | Little-endian scalar inputs, input k in bits 32k+31:32k |
| scalar_out | input | 32*N_OUT | Little-endian scalar results from the core |
| core_mem_addr | input | MEM_AW | Core word address into the local RAM |
| core_mem_we | input | 1 | Core write enable |
| core_mem_wdata | input | 32 | Core write word |
| core_mem_rdata | output | 32 | Local RAM word at core_mem_addr |

## Verification
The checker watches the control sequence on every cycle. It confirms that an idle start produces a single `core_start` pulse together with busy, that no pulse appears while busy, that completion clears busy and sets done, that done holds until a new start, that scalar results are caught on completion, and that errors appear only in access phases. Only the bench scenarios can show the data path. These cover the byte reversal in each configuration, the packing of padded elements into local words as seen on the core port, zeroed padding on readback, and decoding of gaps, the top of the map and misaligned offsets. They also show that writes to results and to the RAM while busy are ignored, and the full write, start, poll and read sequence against a stub core in both byte orders.

// File: rtl/acc_shell_pkg.sv
package acc_shell_pkg;

   typedef enum logic [2:0] {
      RGN_CTRL,
      RGN_IN,
      RGN_OUT,
      RGN_AGG,
      RGN_NONE
   } region_e;

   // reverse the lowest nb bytes of v, zero above them
   function automatic logic [31:0] flip_lanes(input logic [31:0] v, input int nb);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < 4; i++) begin
         if (i < nb) r[8*i +: 8] = v[8*(nb-1-i) +: 8];
      end
      return r;
   endfunction

   // keep the lowest nb bytes of v, zero above them
   function automatic logic [31:0] low_lanes(input logic [31:0] v, input int nb);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < 4; i++) begin
         if (i < nb) r[8*i +: 8] = v[8*i +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/acc_addr_map.sv
module acc_addr_map
   import acc_shell_pkg::*;
#(
   parameter int N_IN     = 2,
   parameter int N_OUT    = 1,
   parameter int N_ELEM   = 4,
   parameter int AGG_BASE = 256
) (
   input  logic [11:0]  addr,
   output region_e      region,
   output logic [9:0]   idx
);
   localparam logic [9:0] IN_LO  = 10'd1;
   localparam logic [9:0] OUT_LO = 10'(1 + N_IN);
   localparam logic [9:0] OUT_HI = 10'(1 + N_IN + N_OUT);
   localparam logic [9:0] AGG_LO = 10'(AGG_BASE / 4);
   localparam logic [9:0] AGG_HI = 10'(AGG_BASE / 4 + N_ELEM);

   logic [9:0] word;
   assign word = addr[11:2];

   always_comb begin
      region = RGN_NONE;
      idx    = '0;
      if (addr[1:0] != 2'b00) begin
         region = RGN_NONE;
      end else if (word == 10'd0) begin
         region = RGN_CTRL;
      end else if (word < OUT_LO) begin
         region = RGN_IN;
         idx    = word - IN_LO;
      end else if (word < OUT_HI) begin
         region = RGN_OUT;
         idx    = word - OUT_LO;
      end else if (word >= AGG_LO && word < AGG_HI) begin
         region = RGN_AGG;
         idx    = word - AGG_LO;
      end
   end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic core_done,
   output logic core_start,
   output logic busy,
   output logic done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_start <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
      end else begin
         core_start <= 1'b0;
         if (start_req && !busy) begin
            core_start <= 1'b1;
            busy       <= 1'b1;
            done       <= 1'b0;
         end else if (busy && core_done) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/acc_scalar_bank.sv
module acc_scalar_bank
   import acc_shell_pkg::*;
#(
   parameter int               N_IN   = 2,
   parameter int               N_OUT  = 1,
   parameter logic [N_IN-1:0]  IN_BE  = '0,
   parameter logic [N_OUT-1:0] OUT_BE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_we,
   input  logic [9:0]          idx,
   input  logic [31:0]         wdata,
   input  logic                capture,
   input  logic [N_OUT*32-1:0] core_out,
   output logic [N_IN*32-1:0]  core_in,
   output logic [N_OUT*32-1:0] out_hold,
   output logic [31:0]         in_rd,
   output logic [31:0]         out_rd
);
   logic [31:0] in_q     [N_IN];
   logic [31:0] in_view  [N_IN];
   logic [31:0] out_q    [N_OUT];
   logic [31:0] out_view [N_OUT];

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      logic [31:0] store_val;
      if (IN_BE[i]) begin : g_swap
         assign store_val  = flip_lanes(wdata, 4);
         assign in_view[i] = flip_lanes(in_q[i], 4);
      end else begin : g_pass
         assign store_val  = wdata;
         assign in_view[i] = in_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_q[i] <= '0;
         end else if (in_we && idx == 10'(i)) begin
            in_q[i] <= store_val;
         end
      end

      assign core_in[32*i +: 32] = in_q[i];
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_out
      if (OUT_BE[j]) begin : g_swap
         assign out_view[j] = flip_lanes(out_q[j], 4);
      end else begin : g_pass
         assign out_view[j] = out_q[j];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q[j] <= '0;
         end else if (capture) begin
            out_q[j] <= core_out[32*j +: 32];
         end
      end

      assign out_hold[32*j +: 32] = out_q[j];
   end

   always_comb begin
      in_rd = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (idx == 10'(i)) in_rd = in_view[i];
      end
   end

   always_comb begin
      out_rd = '0;
      for (int j = 0; j < N_OUT; j++) begin
         if (idx == 10'(j)) out_rd = out_view[j];
      end
   end

endmodule

// File: rtl/acc_agg_store.sv
module acc_agg_store
   import acc_shell_pkg::*;
#(
   parameter int   N_ELEM     = 4,
   parameter int   ELEM_BYTES = 2,
   parameter logic AGG_BE     = 1'b0,
   localparam int  EPW        = 4 / ELEM_BYTES,
   localparam int  MEM_WORDS  = (N_ELEM + EPW - 1) / EPW,
   localparam int  MEM_AW     = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [9:0]        bus_idx,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [MEM_AW-1:0] core_addr,
   input  logic              core_we,
   input  logic [31:0]       core_wdata,
   output logic [31:0]       core_rdata
);
   logic [31:0]       mem [MEM_WORDS];
   logic [MEM_AW-1:0] wsel;
   int                lane;
   logic [31:0]       elem_in;
   logic [31:0]       word_rd;
   logic [31:0]       elem_raw;

   // translate element index into packed word and lane
   if (EPW == 1) begin : g_wide
      assign wsel = MEM_AW'(bus_idx);
      assign lane = 0;
   end else begin : g_packed
      assign wsel = MEM_AW'(bus_idx / 10'(EPW));
      assign lane = int'(bus_idx) % EPW;
   end

   if (AGG_BE) begin : g_swap
      assign elem_in   = flip_lanes(bus_wdata, ELEM_BYTES);
      assign bus_rdata = flip_lanes(elem_raw, ELEM_BYTES);
   end else begin : g_pass
      assign elem_in   = low_lanes(bus_wdata, ELEM_BYTES);
      assign bus_rdata = elem_raw;
   end

   assign word_rd    = mem[wsel];
   assign elem_raw   = low_lanes(word_rd >> (8 * ELEM_BYTES * lane), ELEM_BYTES);
   assign core_rdata = mem[core_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
      end else if (core_we) begin
         mem[core_addr] <= core_wdata;
      end else if (bus_we) begin
         for (int b = 0; b < ELEM_BYTES; b++) begin
            mem[wsel][8*(lane*ELEM_BYTES + b) +: 8] <= elem_in[8*b +: 8];
         end
      end
   end

endmodule

// File: rtl/acc_param_shell.sv
module acc_param_shell
   import acc_shell_pkg::*;
#(
   parameter int               N_IN       = 2,
   parameter int               N_OUT      = 1,
   parameter int               N_ELEM     = 4,
   parameter int               ELEM_BYTES = 2,
   parameter int               AGG_BASE   = 256,
   parameter logic [N_IN-1:0]  IN_BE      = '0,
   parameter logic [N_OUT-1:0] OUT_BE     = '0,
   parameter logic             AGG_BE     = 1'b0,
   localparam int              EPW        = 4 / ELEM_BYTES,
   localparam int              MEM_WORDS  = (N_ELEM + EPW - 1) / EPW,
   localparam int              MEM_AW     = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
   input  logic                pclk,
   input  logic                presetn,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [11:0]         paddr,
   input  logic [31:0]         pwdata,
   output logic [31:0]         prdata,
   output logic                pready,
   output logic                pslverr,
   output logic                core_start,
   input  logic                core_done,
   output logic [N_IN*32-1:0]  scalar_in,
   input  logic [N_OUT*32-1:0] scalar_out,
   input  logic [MEM_AW-1:0]   core_mem_addr,
   input  logic                core_mem_we,
   input  logic [31:0]         core_mem_wdata,
   output logic [31:0]         core_mem_rdata
);
   // elaboration-time configuration checks
   if (!(ELEM_BYTES == 1 || ELEM_BYTES == 2 || ELEM_BYTES == 4)) begin : g_bad_elem
      $error("ELEM_BYTES must be 1, 2 or 4");
   end
   if (N_IN < 1 || N_OUT < 1 || N_ELEM < 1) begin : g_bad_count
      $error("each parameter group needs at least one entry");
   end
   if (AGG_BASE % 4 != 0 || AGG_BASE / 4 < 1 + N_IN + N_OUT) begin : g_bad_base
      $error("AGG_BASE must be word aligned and above the scalar registers");
   end
   if (AGG_BASE + 4 * N_ELEM > 4096) begin : g_bad_size
      $error("parameter map exceeds the 4 KB window");
   end

   region_e     region;
   logic [9:0]  idx;
   logic        access;
   logic        wr;
   logic        busy;
   logic        done;
   logic        start_req;
   logic [31:0] in_rd;
   logic [31:0] out_rd;
   logic [31:0] agg_rd;
   logic [N_OUT*32-1:0] out_hold;

   assign access    = psel && penable;
   assign wr        = access && pwrite;
   assign pready    = 1'b1;
   assign pslverr   = access && (region == RGN_NONE);
   assign start_req = wr && (region == RGN_CTRL) && pwdata[0];

   acc_addr_map #(
      .N_IN     (N_IN),
      .N_OUT    (N_OUT),
      .N_ELEM   (N_ELEM),
      .AGG_BASE (AGG_BASE)
   ) u_map (
      .addr   (paddr),
      .region (region),
      .idx    (idx)
   );

   acc_ctrl u_ctrl (
      .clk        (pclk),
      .rst_n      (presetn),
      .start_req  (start_req),
      .core_done  (core_done),
      .core_start (core_start),
      .busy       (busy),
      .done       (done)
   );

   acc_scalar_bank #(
      .N_IN   (N_IN),
      .N_OUT  (N_OUT),
      .IN_BE  (IN_BE),
      .OUT_BE (OUT_BE)
   ) u_scalars (
      .clk      (pclk),
      .rst_n    (presetn),
      .in_we    (wr && region == RGN_IN),
      .idx      (idx),
      .wdata    (pwdata),
      .capture  (busy && core_done),
      .core_out (scalar_out),
      .core_in  (scalar_in),
      .out_hold (out_hold),
      .in_rd    (in_rd),
      .out_rd   (out_rd)
   );

   acc_agg_store #(
      .N_ELEM     (N_ELEM),
      .ELEM_BYTES (ELEM_BYTES),
      .AGG_BE     (AGG_BE)
   ) u_agg (
      .clk        (pclk),
      .rst_n      (presetn),
      .bus_we     (wr && region == RGN_AGG && !busy),
      .bus_idx    (idx),
      .bus_wdata  (pwdata),
      .bus_rdata  (agg_rd),
      .core_addr  (core_mem_addr),
      .core_we    (core_mem_we),
      .core_wdata (core_mem_wdata),
      .core_rdata (core_mem_rdata)
   );

   always_comb begin
      prdata = '0;
      if (access && !pwrite) begin
         case (region)
            RGN_CTRL: prdata = {29'd0, done, busy, 1'b0};
            RGN_IN:   prdata = in_rd;
            RGN_OUT:  prdata = out_rd;
            RGN_AGG:  prdata = agg_rd;
            default:  prdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/acc_param_shell_chk.sv
module acc_param_shell_chk #(
   parameter int N_OUT = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                psel,
   input logic                penable,
   input logic                pwrite,
   input logic [11:0]         paddr,
   input logic [31:0]         pwdata,
   input logic                pslverr,
   input logic                core_start,
   input logic                core_done,
   input logic                busy,
   input logic                done,
   input logic [N_OUT*32-1:0] scalar_out,
   input logic [N_OUT*32-1:0] out_hold
);

   // R5
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && paddr == 12'h000 && pwdata[0] && !busy)
      |=> (core_start && busy && !done));

   // R5
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !core_start);

   // R6
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && core_done) |=> (!busy && done));

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy) |=> (done || core_start));

   // R4
   out_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && core_done) |=> (out_hold == $past(scalar_out)));

   // R2
   err_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (psel && penable));

endmodule

bind acc_param_shell acc_param_shell_chk #(.N_OUT(N_OUT)) u_chk (
   .clk        (pclk),
   .rst_n      (presetn),
   .psel       (psel),
   .penable    (penable),
   .pwrite     (pwrite),
   .paddr      (paddr),
   .pwdata     (pwdata),
   .pslverr    (pslverr),
   .core_start (core_start),
   .core_done  (core_done),
   .busy       (busy),
   .done       (done),
   .scalar_out (scalar_out),
   .out_hold   (out_hold)
);

// File: tb/acc_param_shell_tb.sv
`timescale 1ns/1ps

module acc_core_stub (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   output logic        done,
   input  logic [63:0] sin,
   output logic [31:0] sout,
   output logic        addr,
   output logic        we,
   output logic [31:0] wdata,
   input  logic [31:0] rdata
);
   logic [4:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (start) cnt <= 5'd12;
      else if (cnt != 5'd0) cnt <= cnt - 5'd1;
   end
   assign done  = (cnt == 5'd1);
   assign we    = (cnt == 5'd1);
   assign addr  = 1'b0;
   assign wdata = {rdata[15:0], rdata[31:16]};
   assign sout  = sin[31:0] + sin[63:32];
endmodule

module acc_param_shell_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prd_a, prd_b;
   logic        rdy_a, rdy_b, err_a, err_b;
   logic        st_a, st_b, dn_a, dn_b;
   logic [63:0] sin_a, sin_b;
   logic [31:0] sout_a, sout_b;
   logic        ma_a, ma_b, mw_a, mw_b;
   logic [31:0] md_a, md_b, mr_a, mr_b;
   int          checks = 0, errors = 0, cur = 0;
   int          pulses_a = 0, pulses_b = 0;

   always #4 clk = ~clk;

   acc_param_shell u_dut (
      .pclk(clk), .presetn(rst_n), .psel(psel_a), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prd_a), .pready(rdy_a), .pslverr(err_a),
      .core_start(st_a), .core_done(dn_a), .scalar_in(sin_a), .scalar_out(sout_a),
      .core_mem_addr(ma_a), .core_mem_we(mw_a), .core_mem_wdata(md_a), .core_mem_rdata(mr_a));

   acc_param_shell #(.IN_BE(2'b11), .OUT_BE(1'b1), .AGG_BE(1'b1)) u_dut_be (
      .pclk(clk), .presetn(rst_n), .psel(psel_b), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prd_b), .pready(rdy_b), .pslverr(err_b),
      .core_start(st_b), .core_done(dn_b), .scalar_in(sin_b), .scalar_out(sout_b),
      .core_mem_addr(ma_b), .core_mem_we(mw_b), .core_mem_wdata(md_b), .core_mem_rdata(mr_b));

   acc_core_stub u_core_a (.clk(clk), .rst_n(rst_n), .start(st_a), .done(dn_a), .sin(sin_a),
      .sout(sout_a), .addr(ma_a), .we(mw_a), .wdata(md_a), .rdata(mr_a));
   acc_core_stub u_core_b (.clk(clk), .rst_n(rst_n), .start(st_b), .done(dn_b), .sin(sin_b),
      .sout(sout_b), .addr(ma_b), .we(mw_b), .wdata(md_b), .rdata(mr_b));

   always @(posedge clk) begin
      if (st_a) pulses_a <= pulses_a + 1;
      if (st_b) pulses_b <= pulses_b + 1;
   end

   function automatic logic [31:0] sw32(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [15:0] sw16(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s dut%0d actual %h expected %h", req, cur, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er, output logic rdy);
      @(negedge clk);
      psel_a = (cur == 0); psel_b = (cur == 1);
      penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      #1;
      rd  = (cur == 0) ? prd_a : prd_b;
      er  = (cur == 0) ? err_a : err_b;
      rdy = (cur == 0) ? rdy_a : rdy_b;
      @(posedge clk);
      #1;
      psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] rd; logic er, rdy;
      xfer(1'b1, a, d, rd, er, rdy);
   endtask

   task automatic rd32(input logic [11:0] a, output logic [31:0] rd);
      logic er, rdy;
      xfer(1'b0, a, 32'h0, rd, er, rdy);
   endtask

   task automatic suite(input int sel, input bit be);
      logic [31:0] rd, ca, cb, sum;
      logic        er, rdy;
      logic [15:0] v [4];
      logic [15:0] e0, e1;
      int          pulses0, polls;
      cur = sel;
      v[0] = 16'h1122; v[1] = 16'h3344; v[2] = 16'h5566; v[3] = 16'h7788;

      // R1 reset state
      rd32(12'h000, rd); check("R1 ctrl after reset", rd, 32'h0);
      rd32(12'h004, rd); check("R1 input reg after reset", rd, 32'h0);
      check("R1 core_start low", {31'd0, (sel == 0) ? st_a : st_b}, 32'h0);

      // R3 scalar inputs
      wr32(12'h004, 32'h1000_0203);
      wr32(12'h008, 32'h0100_0405);
      rd32(12'h004, rd); check("R3 readback in0", rd, 32'h1000_0203);
      rd32(12'h008, rd); check("R3 readback in1", rd, 32'h0100_0405);
      ca = be ? sw32(32'h1000_0203) : 32'h1000_0203;
      cb = be ? sw32(32'h0100_0405) : 32'h0100_0405;
      check("R3 core view in0", (sel == 0) ? sin_a[31:0] : sin_b[31:0], ca);
      check("R3 core view in1", (sel == 0) ? sin_a[63:32] : sin_b[63:32], cb);
      sum = ca + cb;

      // R4 output write ignored
      wr32(12'h00C, 32'hFFFF_FFFF);
      rd32(12'h00C, rd); check("R4 output write ignored", rd, 32'h0);

      // R2 / R11 unmapped and misaligned
      xfer(1'b0, 12'h010, 32'h0, rd, er, rdy);
      check("R2 gap error", {31'd0, er}, 32'h1); check("R2 gap data", rd, 32'h0);
      check("R2 ready high", {31'd0, rdy}, 32'h1);
      xfer(1'b0, 12'h006, 32'h0, rd, er, rdy);
      check("R2 misaligned error", {31'd0, er}, 32'h1);
      xfer(1'b1, 12'h110, 32'h1234_5678, rd, er, rdy);
      check("R11 past last element error", {31'd0, er}, 32'h1);
      xfer(1'b0, 12'h10C, 32'h0, rd, er, rdy);
      check("R11 last element mapped", {31'd0, er}, 32'h0);
      xfer(1'b0, 12'h000, 32'h0, rd, er, rdy);
      check("R2 ctrl no error", {31'd0, er}, 32'h0);

      // R8 / R9 aggregate packing with padding
      for (int i = 0; i < 4; i++) wr32(12'h100 + 12'(4*i), {16'hDEAD, v[i]});
      for (int i = 0; i < 4; i++) begin
         rd32(12'h100 + 12'(4*i), rd);
         check("R8 element readback padding zero", rd, {16'h0, v[i]});
      end
      e0 = be ? sw16(v[0]) : v[0];
      e1 = be ? sw16(v[1]) : v[1];
      check("R9 packed local word", (sel == 0) ? mr_a : mr_b, {e1, e0});

      // R5 start
      pulses0 = (sel == 0) ? pulses_a : pulses_b;
      wr32(12'h000, 32'h0000_0001);
      rd32(12'h000, rd); check("R5 busy after start", rd, 32'h0000_0002);
      // R7 start while busy
      wr32(12'h000, 32'h0000_0001);
      // R10 aggregate write while busy
      wr32(12'h108, 32'h0000_FFFF);

      // R6 poll
      polls = 0;
      rd32(12'h000, rd);
      while (rd[2] == 1'b0 && polls < 100) begin
         rd32(12'h000, rd);
         polls++;
      end
      check("R6 done after completion", rd, 32'h0000_0004);
      rd32(12'h000, rd); check("R6 done holds", rd, 32'h0000_0004);
      check("R7 one start pulse", 32'((sel == 0) ? pulses_a : pulses_b) - 32'(pulses0), 32'd1);
      rd32(12'h108, rd); check("R10 write while busy ignored", rd, {16'h0, v[2]});

      // R4 result
      rd32(12'h00C, rd); check("R4 result", rd, be ? sw32(sum) : sum);

      // R8 / R9 reversed array
      rd32(12'h100, rd); check("R9 reversed elem0", rd, {16'h0, v[1]});
      rd32(12'h104, rd); check("R9 reversed elem1", rd, {16'h0, v[0]});
      rd32(12'h10C, rd); check("R8 untouched elem3", rd, {16'h0, v[3]});

      // R5 restart clears done
      wr32(12'h000, 32'h0000_0001);
      rd32(12'h000, rd); check("R5 restart clears done", rd, 32'h0000_0002);
      polls = 0;
      rd32(12'h000, rd);
      while (rd[2] == 1'b0 && polls < 100) begin
         rd32(12'h000, rd);
         polls++;
      end
      rd32(12'h100, rd); check("R9 second reversal elem0", rd, {16'h0, v[0]});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      suite(0, 1'b0);
      suite(1, 1'b1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule